// File: doc/BRIEF.md
# Trailing Bit Manipulation Unit

This unit transforms a single operand into one of nine masks built around its lowest set bit or its lowest clear bit. Each result is made from four ingredients: the operand, its bitwise complement, the operand plus one and the operand minus one. Both the increment and the decrement wrap modulo two to the power of the datapath width. A 4-bit operation code selects the function. Every function gives a defined result even when the operand has no qualifying bit, for example an all-ones operand that has no clear bit, or a zero operand that has no set bit.

A caller raises `in_valid` with an opcode and an operand. One clock later `out_valid` is high and `out_result` holds the answer. The datapath width is the parameter `WIDTH`. It is meant to be 32 or 64, and any width of four or more elaborates. The output stage is a two-state machine. `ST_EMPTY` means no result was produced on the last edge, and `ST_FULL` means a result was captured on the last edge. There are two transitions: `GO_FULL` is taken on an edge where `in_valid` is high, from either state, and `GO_EMPTY` is taken on an edge where `in_valid` is low, from either state. Reset forces `ST_EMPTY`.

Top module: `tbm_unit`

## Requirements
- R1: Opcode 0 returns x AND (x+1), which clears the run of ones below the lowest clear bit. An all-ones operand gives zero.
- R2: Opcode 1 returns x OR NOT(x+1). Every bit is one except the lowest clear bit, and an all-ones operand gives all ones.
- R3: Opcode 2 returns NOT x AND (x+1). Only the lowest clear bit is set, so at most one bit is set, and an all-ones operand gives zero.
- R4: Opcode 3 returns x XOR (x+1). The lowest clear bit and every bit below it are set, and an all-ones operand gives all ones.
- R5: Opcode 4 returns x OR (x+1), which sets the lowest clear bit. An all-ones operand returns itself.
- R6: Opcode 5 returns x OR (x-1), which sets every bit below the lowest set bit. A zero operand gives all ones.
- R7: Opcode 6 returns NOT x OR (x-1). Only the lowest set bit is cleared, so at most one bit is zero, and a zero operand gives all ones.
- R8: Opcode 7 returns NOT x OR (x+1), which clears the trailing ones and sets everything else. A zero operand gives all ones.
- R9: Opcode 8 returns NOT x AND (x-1), a mask of the trailing zeros. An operand with bit 0 set gives zero, and a zero operand gives all ones.
- R10: Opcodes 9 to 15 return zero.
- R11: After an edge with `in_valid` high, `out_valid` is high and `out_result` holds the function of that opcode and operand. After an edge with `in_valid` low, `out_valid` is low and `out_result` keeps its previous value.
- R12: A synchronous active-high `rst` clears `out_valid` and `out_result` at the next edge.
- R13: The increment and decrement wrap modulo 2^WIDTH, so the functions hold at a 32-bit width, including operands with the top bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe |
| in_op | input | 4 | Operation code |
| in_x | input | WIDTH | Operand |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_result | output | WIDTH | Registered result |

## Verification
The bench sweeps every 8-bit operand through all sixteen opcodes and compares each result with a reference computed in the bench. This covers the zero and all-ones operands, where a wrong carry or borrow would show up as a lost or extra bit. A unit that did not wrap the increment would turn all-ones into a result with a stray set bit instead of zero. A unit that decoded the unused opcodes loosely would alias them onto real functions and return non-zero values. The bench also runs a 32-bit instance on operands with the high bit set, which catches truncated adders. It checks that an idle cycle drops `out_valid` without disturbing the held result, and that reset clears both outputs.

// File: rtl/tbm_pkg.sv
package tbm_pkg;

    typedef enum logic [3:0] {
        OP_CLR_LOWZ_RUN = 4'd0,
        OP_ALL_BUT_LOWZ = 4'd1,
        OP_ONLY_LOWZ    = 4'd2,
        OP_MASK_TO_LOWZ = 4'd3,
        OP_SET_LOWZ     = 4'd4,
        OP_FILL_BELOW_1 = 4'd5,
        OP_ALL_BUT_LOW1 = 4'd6,
        OP_CLR_TRAIL_1S = 4'd7,
        OP_TRAIL_0_MASK = 4'd8
    } tbm_op_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } tbm_state_e;

    localparam int unsigned OP_BITS = 4;

endpackage

// File: rtl/tbm_adjust.sv
module tbm_adjust #(
    parameter int unsigned WIDTH = 64
) (
    input  logic [WIDTH-1:0] x,
    output logic [WIDTH-1:0] x_inc,
    output logic [WIDTH-1:0] x_dec,
    output logic [WIDTH-1:0] x_inv
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    // Results are truncated to WIDTH, which gives wrap modulo 2^WIDTH.
    always_comb begin
        x_inc = x + ONE;
        x_dec = x - ONE;
        x_inv = ~x;
    end

endmodule

// File: rtl/tbm_select.sv
module tbm_select
    import tbm_pkg::*;
#(
    parameter int unsigned WIDTH = 64
) (
    input  logic [OP_BITS-1:0] op,
    input  logic [WIDTH-1:0]   x,
    input  logic [WIDTH-1:0]   x_inc,
    input  logic [WIDTH-1:0]   x_dec,
    input  logic [WIDTH-1:0]   x_inv,
    output logic [WIDTH-1:0]   y
);

    tbm_op_e op_e;

    always_comb begin
        op_e = tbm_op_e'(op);
        unique case (op_e)
            OP_CLR_LOWZ_RUN: y = x     &  x_inc;
            OP_ALL_BUT_LOWZ: y = x     | ~x_inc;
            OP_ONLY_LOWZ:    y = x_inv &  x_inc;
            OP_MASK_TO_LOWZ: y = x     ^  x_inc;
            OP_SET_LOWZ:     y = x     |  x_inc;
            OP_FILL_BELOW_1: y = x     |  x_dec;
            OP_ALL_BUT_LOW1: y = x_inv |  x_dec;
            OP_CLR_TRAIL_1S: y = x_inv |  x_inc;
            OP_TRAIL_0_MASK: y = x_inv &  x_dec;
            default:         y = '0;
        endcase
    end

endmodule

// File: rtl/tbm_outreg.sv
module tbm_outreg
    import tbm_pkg::*;
#(
    parameter int unsigned WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic             valid,
    output logic [WIDTH-1:0] q
);

    tbm_state_e state_q;
    tbm_state_e state_d;

    // Transition GO_FULL on a strobe, GO_EMPTY otherwise.
    always_comb begin
        unique case (state_q)
            ST_EMPTY: state_d = load ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_d = load ? ST_FULL : ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_EMPTY;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end

    assign valid = (state_q == ST_FULL);

endmodule

// File: rtl/tbm_unit.sv
module tbm_unit
    import tbm_pkg::*;
#(
    parameter int unsigned WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [3:0]       in_op,
    input  logic [WIDTH-1:0] in_x,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_result
);

    logic [WIDTH-1:0] x_inc;
    logic [WIDTH-1:0] x_dec;
    logic [WIDTH-1:0] x_inv;
    logic [WIDTH-1:0] y;

    tbm_adjust #(.WIDTH(WIDTH)) u_adjust (
        .x     (in_x),
        .x_inc (x_inc),
        .x_dec (x_dec),
        .x_inv (x_inv)
    );

    tbm_select #(.WIDTH(WIDTH)) u_select (
        .op    (in_op),
        .x     (in_x),
        .x_inc (x_inc),
        .x_dec (x_dec),
        .x_inv (x_inv),
        .y     (y)
    );

    tbm_outreg #(.WIDTH(WIDTH)) u_outreg (
        .clk   (clk),
        .rst   (rst),
        .load  (in_valid),
        .d     (y),
        .valid (out_valid),
        .q     (out_result)
    );

endmodule

// File: rtl/tbm_unit_chk.sv
module tbm_unit_chk #(
    parameter int unsigned WIDTH = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [3:0]       in_op,
    input logic [WIDTH-1:0] in_x,
    input logic             out_valid,
    input logic [WIDTH-1:0] out_result
);

    // R12
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && out_result == '0));

    // R11
    strobe_valid_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_result)));

    // R10
    unused_op_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op > 4'd8) |=> out_result == '0);

    // R3
    only_lowz_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 4'd2) |=> $onehot0(out_result));

    // R7
    all_but_low1_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 4'd6) |=> ($countones(~out_result) <= 1));

    // R9
    trail0_odd_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 4'd8 && in_x[0]) |=> out_result == '0);

endmodule

bind tbm_unit tbm_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_x       (in_x),
    .out_valid  (out_valid),
    .out_result (out_result)
);

// File: tb/tbm_unit_bench.sv
module tbm_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  in_op = '0;
    logic [7:0]  in_x8 = '0;
    logic [31:0] in_x32 = '0;
    logic        v8, v32;
    logic [7:0]  r8;
    logic [31:0] r32;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    tbm_unit #(.WIDTH(8)) u_tbm_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_x(in_x8), .out_valid(v8), .out_result(r8)
    );

    tbm_unit #(.WIDTH(32)) u_tbm_unit_w32 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_x(in_x32), .out_valid(v32), .out_result(r32)
    );

    function automatic logic [63:0] model(int w, logic [3:0] op, logic [63:0] xin);
        logic [63:0] mask, x, p, m, n;
        mask = (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
        x = xin & mask;
        p = (x + 64'd1) & mask;
        m = (x - 64'd1) & mask;
        n = ~x & mask;
        case (op)
            4'd0: return x & p;
            4'd1: return (x | ~p) & mask;
            4'd2: return n & p;
            4'd3: return x ^ p;
            4'd4: return x | p;
            4'd5: return x | m;
            4'd6: return n | m;
            4'd7: return n | p;
            4'd8: return n & m;
            default: return 64'd0;
        endcase
    endfunction

    function automatic string req_of(logic [3:0] op);
        case (op)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2: return "R3";
            4'd3: return "R4";
            4'd4: return "R5";
            4'd5: return "R6";
            4'd6: return "R7";
            4'd7: return "R8";
            4'd8: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] op, input logic [31:0] x);
        logic [63:0] e8, e32;
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_x8 = x[7:0]; in_x32 = x;
        e8  = model(8, op, {56'd0, x[7:0]});
        e32 = model(32, op, {32'd0, x});
        @(negedge clk);
        check(v8 && {56'd0, r8} == e8, req_of(op), {55'd0, v8, r8}, {55'd0, 1'b1, e8[7:0]});
        check(v32 && {32'd0, r32} == e32, {req_of(op), " R13"}, {31'd0, v32, r32},
              {31'd0, 1'b1, e32[31:0]});
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check(!v8 && r8 == 0 && !v32 && r32 == 0, "R12", {31'd0, v8, 24'd0, r8}, 64'd0);
        rst = 1'b0;

        // R1 .. R10: exhaustive 8-bit sweep of all opcodes
        for (int op = 0; op < 16; op++)
            for (int x = 0; x < 256; x++)
                apply(op[3:0], x[7:0]);

        // R13: 32-bit operands with high bits set
        for (int op = 0; op < 16; op++) begin
            apply(op[3:0], 32'hFFFF_FFFF);
            apply(op[3:0], 32'h8000_0000);
            apply(op[3:0], 32'h7FFF_FFFF);
            apply(op[3:0], 32'hF0F0_0057);
        end

        // R11: idle cycle drops valid and holds result
        apply(4'd4, 32'h0000_0051);
        @(negedge clk);
        in_valid = 1'b0; in_op = 4'd1; in_x8 = 8'h00; in_x32 = 32'h0;
        @(negedge clk);
        check(!v8 && r8 == 8'h53, "R11", {55'd0, v8, r8}, 64'h53);
        check(!v32 && r32 == 32'h53, "R11", {31'd0, v32, r32}, 64'h53);

        // R12: reset after a non-zero result
        apply(4'd5, 32'h0000_0054);
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        check(!v8 && r8 == 0 && !v32 && r32 == 0, "R12", {31'd0, v8, 24'd0, r8}, 64'd0);
        rst = 1'b0; in_valid = 1'b0;

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule